// File: doc/BRIEF.md
# Value Register Readiness and In-Order Retirement Tracker

This block sits beside a register renamer in an out-of-order core. It keeps one ready flag and one data word for each value register. When the renamer hands out a fresh destination name, that name's flag drops to not-ready. When a functional unit writes a result back, the flag rises and the data is stored. Source lookups from issue and reservation logic read the flag and the data without waiting for a clock edge. A writeback in the same cycle is forwarded to the lookup.

Each allocation also pushes an entry onto a circular in-flight queue, in issue order. The entry holds the new destination name and the name that the same architectural register used before. Only the oldest entry can retire, and only once its own destination shows ready. On retirement the block presents the older name so the free pool can reclaim it. The destination name itself stays live, because it is now the committed mapping.

Top module: `vr_commit_tracker`

## Requirements
- R1: After reset every value register reads ready with data zero, `alloc_ready_o` is 1 and `commit_valid_o` is 0.
- R2: An accepted allocation (`alloc_valid_i` and `alloc_ready_o` both 1 at a rising edge) makes `alloc_dst_i` read not-ready from the next cycle on, until a later writeback to it.
- R3: A writeback (`wb_valid_i` at a rising edge) makes `wb_name_i` read ready with data `wb_data_i` from the next cycle on.
- R4: A status query whose name equals `wb_name_i` while `wb_valid_i` is 1 returns ready and `wb_data_i` in the same cycle. Any other query returns the stored flag and data.
- R5: `commit_valid_o` is 1 only when the queue holds at least one entry and the stored flag of the oldest entry's destination is ready. A ready younger entry never retires ahead of the oldest.
- R6: While `commit_valid_o` is 1, `commit_dst_o` and `commit_free_o` carry the destination and the previous name of the oldest entry. The entry is removed at that rising edge.
- R7: A writeback to the oldest entry's destination does not raise `commit_valid_o` in the same cycle. Retirement happens in the cycle after it.
- R8: When DEPTH entries are in flight, `alloc_ready_o` is 0. An allocation offered then is dropped: no entry is queued and its destination keeps its flag.
- R9: At most one entry retires per cycle. Entries retire in the order they were allocated.
- R10: If an accepted allocation and a writeback name the same register in the same cycle, the allocation wins. The register reads not-ready afterwards, and the writeback's data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Renamer offers a new in-flight instruction |
| alloc_dst_i | input | NAME_W | Newly assigned destination value register |
| alloc_old_i | input | NAME_W | Value register previously mapped to the same architectural register |
| alloc_ready_o | output | 1 | Queue has room; an offered allocation is accepted |
| wb_valid_i | input | 1 | Functional unit result is valid |
| wb_name_i | input | NAME_W | Value register being written |
| wb_data_i | input | DATA_W | Result data |
| qry_name_i | input | NUM_QRY*NAME_W | Source names to look up, port k in bits [k*NAME_W +: NAME_W] |
| qry_ready_o | output | NUM_QRY | Ready flag per query port |
| qry_data_o | output | NUM_QRY*DATA_W | Data per query port, port k in bits [k*DATA_W +: DATA_W] |
| commit_valid_o | output | 1 | Oldest in-flight instruction retires this cycle |
| commit_dst_o | output | NAME_W | Destination of the retiring instruction |
| commit_free_o | output | NAME_W | Previous name released to the free pool |

## Verification
Suppose a flag is wrong, or a queue pointer or count drifts. The next status query of the affected name then returns the wrong ready bit or data. `alloc_ready_o` goes wrong, or `commit_valid_o` and the retired names disagree with issue order, within one cycle of the corrupting edge. So the bench compares every output in every cycle against a model derived from the requirements. The directed phases cover the full queue, the same-cycle writeback to the head, and the allocation/writeback collision. A long mixed sweep then biases writebacks toward the head, so that retirement runs often.

// File: rtl/vr_track_pkg.sv
package vr_track_pkg;
  localparam int unsigned DEF_NUM_VREGS = 64;
  localparam int unsigned DEF_DEPTH     = 64;
  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_NUM_QRY   = 2;

  typedef enum logic [1:0] {
    Q_IDLE = 2'b00,
    Q_POP  = 2'b01,
    Q_PUSH = 2'b10,
    Q_BOTH = 2'b11
  } q_op_e;
endpackage

// File: rtl/vr_status_file.sv
module vr_status_file #(
  parameter int unsigned NUM_VREGS = 64,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_QRY   = 2,
  localparam int unsigned NAME_W   = $clog2(NUM_VREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic [NAME_W-1:0]         clr_name_i,
  input  logic                      wb_valid_i,
  input  logic [NAME_W-1:0]         wb_name_i,
  input  logic [DATA_W-1:0]         wb_data_i,
  input  logic [NUM_QRY*NAME_W-1:0] qry_name_i,
  output logic [NUM_QRY-1:0]        qry_ready_o,
  output logic [NUM_QRY*DATA_W-1:0] qry_data_o,
  input  logic [NAME_W-1:0]         head_name_i,
  output logic                      head_ready_o
);
  logic [NUM_VREGS-1:0] rdy_q;
  logic [DATA_W-1:0]    val_q [NUM_VREGS];

  for (genvar g = 0; g < NUM_VREGS; g++) begin : g_reg
    logic hit_clr, hit_wb;
    assign hit_clr = clr_i && (clr_name_i == NAME_W'(g));
    assign hit_wb  = wb_valid_i && (wb_name_i == NAME_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdy_q[g] <= 1'b1;
        val_q[g] <= '0;
      end else if (hit_clr) begin
        rdy_q[g] <= 1'b0;  // allocation beats a colliding writeback
      end else if (hit_wb) begin
        rdy_q[g] <= 1'b1;
        val_q[g] <= wb_data_i;
      end
    end
  end

  for (genvar q = 0; q < NUM_QRY; q++) begin : g_qry
    logic [NAME_W-1:0] name;
    logic              byp;
    assign name = qry_name_i[q*NAME_W +: NAME_W];
    assign byp  = wb_valid_i && (wb_name_i == name);
    assign qry_ready_o[q]              = byp | rdy_q[name];
    assign qry_data_o[q*DATA_W +: DATA_W] = byp ? wb_data_i : val_q[name];
  end

  // registered flag only: a same-cycle writeback waits one cycle to retire
  assign head_ready_o = rdy_q[head_name_i];
endmodule

// File: rtl/vr_inflight_queue.sv
module vr_inflight_queue
  import vr_track_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned NAME_W = 6,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [NAME_W-1:0] push_dst_i,
  input  logic [NAME_W-1:0] push_old_i,
  input  logic              pop_i,
  output logic [NAME_W-1:0] head_dst_o,
  output logic [NAME_W-1:0] head_old_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [NAME_W-1:0] dst_q [DEPTH];
  logic [NAME_W-1:0] old_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;
  q_op_e             op;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign op      = q_op_e'({push_i, pop_i});
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      unique case (op)
        Q_PUSH:  cnt_q <= cnt_q + CNT_W'(1);
        Q_POP:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      dst_q[wr_q] <= push_dst_i;
      old_q[wr_q] <= push_old_i;
    end
  end

  assign head_dst_o = dst_q[rd_q];
  assign head_old_o = old_q[rd_q];
endmodule

// File: rtl/vr_commit_tracker.sv
module vr_commit_tracker
  import vr_track_pkg::*;
#(
  parameter int unsigned NUM_VREGS = DEF_NUM_VREGS,
  parameter int unsigned DEPTH     = DEF_DEPTH,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned NUM_QRY   = DEF_NUM_QRY,
  localparam int unsigned NAME_W   = $clog2(NUM_VREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_valid_i,
  input  logic [NAME_W-1:0]         alloc_dst_i,
  input  logic [NAME_W-1:0]         alloc_old_i,
  output logic                      alloc_ready_o,
  input  logic                      wb_valid_i,
  input  logic [NAME_W-1:0]         wb_name_i,
  input  logic [DATA_W-1:0]         wb_data_i,
  input  logic [NUM_QRY*NAME_W-1:0] qry_name_i,
  output logic [NUM_QRY-1:0]        qry_ready_o,
  output logic [NUM_QRY*DATA_W-1:0] qry_data_o,
  output logic                      commit_valid_o,
  output logic [NAME_W-1:0]         commit_dst_o,
  output logic [NAME_W-1:0]         commit_free_o
);
  logic push, empty, full, head_rdy;
  logic [NAME_W-1:0] head_dst, head_old;

  assign alloc_ready_o = !full;
  assign push          = alloc_valid_i && !full;

  vr_inflight_queue #(.DEPTH(DEPTH), .NAME_W(NAME_W)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_dst_i (alloc_dst_i),
    .push_old_i (alloc_old_i),
    .pop_i      (commit_valid_o),
    .head_dst_o (head_dst),
    .head_old_o (head_old),
    .empty_o    (empty),
    .full_o     (full)
  );

  vr_status_file #(
    .NUM_VREGS(NUM_VREGS), .DATA_W(DATA_W), .NUM_QRY(NUM_QRY)
  ) u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (push),
    .clr_name_i   (alloc_dst_i),
    .wb_valid_i   (wb_valid_i),
    .wb_name_i    (wb_name_i),
    .wb_data_i    (wb_data_i),
    .qry_name_i   (qry_name_i),
    .qry_ready_o  (qry_ready_o),
    .qry_data_o   (qry_data_o),
    .head_name_i  (head_dst),
    .head_ready_o (head_rdy)
  );

  assign commit_valid_o = !empty && head_rdy;
  assign commit_dst_o   = head_dst;
  assign commit_free_o  = head_old;
endmodule

// File: rtl/vr_commit_tracker_chk.sv
module vr_commit_tracker_chk #(
  parameter int unsigned NUM_VREGS = 64,
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_QRY   = 2,
  localparam int unsigned NAME_W   = $clog2(NUM_VREGS),
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      alloc_valid_i,
  input logic [NAME_W-1:0]         alloc_dst_i,
  input logic                      alloc_ready_o,
  input logic                      wb_valid_i,
  input logic [NAME_W-1:0]         wb_name_i,
  input logic [DATA_W-1:0]         wb_data_i,
  input logic [NUM_QRY*NAME_W-1:0] qry_name_i,
  input logic [NUM_QRY-1:0]        qry_ready_o,
  input logic [NUM_QRY*DATA_W-1:0] qry_data_o,
  input logic                      commit_valid_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             past_ok;
  logic             fire;

  assign fire = alloc_valid_i && alloc_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      cnt_q   <= cnt_q + CNT_W'(fire) - CNT_W'(commit_valid_o);
    end
  end

  a_r5_no_commit_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !commit_valid_o);

  a_r8_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH)) == !alloc_ready_o);

  for (genvar q = 0; q < NUM_QRY; q++) begin : g_q
    logic [NAME_W-1:0] qn;
    assign qn = qry_name_i[q*NAME_W +: NAME_W];

    a_r4_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_valid_i && wb_name_i == qn) |-> (qry_ready_o[q] && qry_data_o[q*DATA_W +: DATA_W] == wb_data_i));

    a_r3_wb_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $past(wb_valid_i) && qn == $past(wb_name_i)
       && !($past(fire) && $past(alloc_dst_i) == $past(wb_name_i))) |-> qry_ready_o[q]);

    a_r2_alloc_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $past(fire) && qn == $past(alloc_dst_i)
       && !(wb_valid_i && wb_name_i == qn)) |-> !qry_ready_o[q]);
  end
endmodule

bind vr_commit_tracker vr_commit_tracker_chk #(
  .NUM_VREGS(NUM_VREGS), .DEPTH(DEPTH), .DATA_W(DATA_W), .NUM_QRY(NUM_QRY)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_dst_i    (alloc_dst_i),
  .alloc_ready_o  (alloc_ready_o),
  .wb_valid_i     (wb_valid_i),
  .wb_name_i      (wb_name_i),
  .wb_data_i      (wb_data_i),
  .qry_name_i     (qry_name_i),
  .qry_ready_o    (qry_ready_o),
  .qry_data_o     (qry_data_o),
  .commit_valid_o (commit_valid_o)
);

// File: tb/tb_vr_commit_tracker.sv
module tb_vr_commit_tracker;
  localparam int NV = 16;
  localparam int DP = 8;
  localparam int DW = 8;
  localparam int NQ = 2;
  localparam int NW = $clog2(NV);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic [NW-1:0] alloc_dst = '0, alloc_old = '0;
  logic alloc_ready;
  logic wb_valid = 1'b0;
  logic [NW-1:0] wb_name = '0;
  logic [DW-1:0] wb_data = '0;
  logic [NQ*NW-1:0] qry_name = '0;
  logic [NQ-1:0] qry_ready;
  logic [NQ*DW-1:0] qry_data;
  logic commit_valid;
  logic [NW-1:0] commit_dst, commit_free;

  always #10 clk = ~clk;

  vr_commit_tracker #(.NUM_VREGS(NV), .DEPTH(DP), .DATA_W(DW), .NUM_QRY(NQ)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_dst_i(alloc_dst), .alloc_old_i(alloc_old),
    .alloc_ready_o(alloc_ready),
    .wb_valid_i(wb_valid), .wb_name_i(wb_name), .wb_data_i(wb_data),
    .qry_name_i(qry_name), .qry_ready_o(qry_ready), .qry_data_o(qry_data),
    .commit_valid_o(commit_valid), .commit_dst_o(commit_dst), .commit_free_o(commit_free)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model
  logic          m_rdy [NV];
  logic [DW-1:0] m_val [NV];
  logic [NW-1:0] m_dst [DP];
  logic [NW-1:0] m_old [DP];
  int m_head = 0, m_cnt = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    logic ecv, ear;
    @(negedge clk);
    ear = (m_cnt != DP);
    ecv = (m_cnt != 0) && m_rdy[m_dst[m_head]];
    chk(tag, "R8 alloc_ready", 32'(alloc_ready), 32'(ear));
    chk(tag, "R5 commit_valid", 32'(commit_valid), 32'(ecv));
    if (ecv) begin
      chk(tag, "R6 commit_dst", 32'(commit_dst), 32'(m_dst[m_head]));
      chk(tag, "R6 commit_free", 32'(commit_free), 32'(m_old[m_head]));
    end
    for (int q = 0; q < NQ; q++) begin
      logic [NW-1:0] n;
      logic byp;
      n = qry_name[q*NW +: NW];
      byp = wb_valid && wb_name == n;
      chk(tag, "R4 qry_ready", 32'(qry_ready[q]), 32'(byp | m_rdy[n]));
      chk(tag, "R3 qry_data", 32'(qry_data[q*DW +: DW]), 32'(byp ? wb_data : m_val[n]));
    end
    @(posedge clk);
    if (ecv) begin
      m_head = (m_head + 1) % DP;
      m_cnt--;
    end
    if (wb_valid && !(alloc_valid && ear && alloc_dst == wb_name)) begin
      m_rdy[wb_name] = 1'b1;
      m_val[wb_name] = wb_data;
    end
    if (alloc_valid && ear) begin
      m_dst[(m_head + m_cnt) % DP] = alloc_dst;
      m_old[(m_head + m_cnt) % DP] = alloc_old;
      m_rdy[alloc_dst] = 1'b0;
      m_cnt++;
    end
    #1;
  endtask

  task automatic idle();
    alloc_valid = 1'b0;
    wb_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      m_rdy[i] = 1'b1;
      m_val[i] = '0;
    end
    for (int i = 0; i < DP; i++) begin
      m_dst[i] = '0;
      m_old[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, sweep every name on both ports
    for (int n = 0; n < NV; n++) begin
      qry_name = {NW'((n + 1) % NV), NW'(n)};
      tick("R1");
    end

    // R2 / R8: fill the queue, dst = i+8, old = i
    for (int i = 0; i < DP; i++) begin
      alloc_valid = 1'b1;
      alloc_dst = NW'(i + 8);
      alloc_old = NW'(i);
      qry_name = {NW'(i + 7), NW'(i + 8)};
      tick("R2");
    end
    idle();
    qry_name = {NW'(15), NW'(8)};
    tick("R2");

    // R8: full, offered allocation of name 3 must be dropped
    alloc_valid = 1'b1;
    alloc_dst = NW'(3);
    alloc_old = NW'(5);
    qry_name = {NW'(3), NW'(3)};
    tick("R8");
    idle();
    tick("R8");

    // R5: younger entry ready does not retire; R4 bypass during writeback
    wb_valid = 1'b1;
    wb_name = NW'(9);
    wb_data = 8'h5a;
    qry_name = {NW'(8), NW'(9)};
    tick("R4");
    idle();
    tick("R5");

    // R7: writeback to head; no retire this cycle, retire next
    wb_valid = 1'b1;
    wb_name = NW'(8);
    wb_data = 8'hc3;
    tick("R7");
    idle();
    tick("R7");
    // R9: entry 9 already ready retires right after, one per cycle
    tick("R9");
    tick("R9");

    // R10: allocation and writeback on the same name
    alloc_valid = 1'b1;
    alloc_dst = NW'(0);
    alloc_old = NW'(8);
    wb_valid = 1'b1;
    wb_name = NW'(0);
    wb_data = 8'h77;
    qry_name = {NW'(1), NW'(0)};
    tick("R10");
    idle();
    tick("R10");

    // mixed sweep
    for (int k = 0; k < 3000; k++) begin
      alloc_valid = $urandom_range(0, 1) == 1;
      alloc_dst = NW'($urandom_range(0, NV - 1));
      alloc_old = NW'($urandom_range(0, NV - 1));
      wb_valid = $urandom_range(0, 2) != 0;
      if ($urandom_range(0, 1) == 1 && m_cnt != 0) wb_name = m_dst[m_head];
      else wb_name = NW'($urandom_range(0, NV - 1));
      wb_data = DW'($urandom);
      qry_name = {NW'($urandom_range(0, NV - 1)),
                  ($urandom_range(0, 3) == 0) ? wb_name : NW'($urandom_range(0, NV - 1))};
      tick("R9");
    end
    idle();
    repeat (DP + 2) tick("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule